// File: doc/BRIEF.md
# Ready Status Supervisor with Link Watchdog

This block decides whether a gate drive channel may report itself ready and whether the gate must be held off. It watches three health sources: an input-side supply-good flag, an output-side supply-good flag, and a periodic link-alive strobe that stands in for the internal command transmission across the isolation barrier. A watchdog reloads on every strobe. If no strobe arrives within the timeout, the link is declared dead.

The output-side supply flag and the link health each pass through a qualification delay before they can raise the ready flag. The delay applies only when a source becomes healthy. Any loss of health takes ready down at the next clock edge. Nothing is latched, so ready returns without a reset once every source is healthy and qualified again. The force-off output goes to the gate logic. It is high while either supply is bad, while the output supply is still qualifying, or while the link watchdog has expired.

Both outputs are registered. The block uses a synchronous active-high reset.

Top module: `rsv_ready_supervisor`

## Requirements
- R1: While reset is high, and at the first edge after it, ready is 0 and force_off is 1.
- R2: Ready is 1 only when in_supply_ok and out_supply_ok were both 1 at the previous edge, the link is alive and the link health has been qualified.
- R3: After out_supply_ok rises, ready can be 1 only after out_supply_ok has been sampled high at OUT_QUAL+1 consecutive edges. With all other sources healthy, ready rises exactly after the (OUT_QUAL+1)-th such edge.
- R4: On a dead link, the first strobe makes the link alive at its own edge. With both supplies healthy and qualified, ready rises exactly LINK_QUAL+1 edges after the strobe edge.
- R5: Each strobe reloads the watchdog. If WDOG_TIMEOUT edges pass after a strobe edge with no further strobe, force_off becomes 1 and ready becomes 0 one edge later. Strobes spaced exactly WDOG_TIMEOUT edges apart keep ready at 1.
- R6: If either supply flag is 0 at an edge, ready is 0 and force_off is 1 after the next edge. No delay applies to a loss.
- R7: Ready is non-latching. After a failure it returns with no reset once the sources are healthy again, and a one-cycle in_supply_ok dropout is fully recovered one edge after the flag returns.
- R8: force_off is 0 only when the input supply is good, the output supply is good and qualified, and the link is alive. Link qualification does not hold force_off, and ready=1 implies force_off=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_supply_ok | input | 1 | Input-side supply good, synchronous level |
| out_supply_ok | input | 1 | Output-side supply good, synchronous level |
| link_strobe | input | 1 | Link-alive pulse, one cycle per event |
| ready | output | 1 | Registered ready indication |
| force_off | output | 1 | Registered gate-off override |

## Verification
The assertions assume that all three inputs are already synchronous to clk. They also assume that link_strobe is a single-cycle pulse that is sampled once per edge, and that the supply flags are clean levels. The bench meets these assumptions by changing every input one time unit after a rising edge and by driving link_strobe for exactly one cycle per event. The strobe spacing is always either within the timeout or deliberately beyond it, and is counted in whole edges.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;
  localparam int QUAL_OUT  = 0;
  localparam int QUAL_LINK = 1;
  localparam int NUM_QUAL  = 2;

  typedef struct packed {
    logic in_ok;
    logic out_ok;
    logic out_qual;
    logic link_alive;
    logic link_qual;
  } health_t;

  function automatic logic gate_permit(input health_t h);
    return h.in_ok & h.out_ok & h.out_qual & h.link_alive;
  endfunction

  function automatic logic ready_permit(input health_t h);
    return gate_permit(h) & h.link_qual;
  endfunction
endpackage

// File: rtl/rsv_qualifier.sv
`timescale 1ns/1ps
// Rising-direction qualifier: output goes high after DELAY consecutive high
// samples, and drops at the first low sample.
module rsv_qualifier #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_ok,
  output logic qual_ok
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !raw_ok) begin
      cnt     <= '0;
      qual_ok <= 1'b0;
    end else if (!qual_ok) begin
      if (cnt == LAST) qual_ok <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsv_watchdog.sv
`timescale 1ns/1ps
// Link watchdog: reloads on each strobe and declares the link dead when
// TIMEOUT edges pass without one.
module rsv_watchdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic alive
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [CW-1:0] NEAR  = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= LIMIT;
      alive <= 1'b0;
    end else if (strobe) begin
      cnt   <= '0;
      alive <= 1'b1;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
      if (cnt == NEAR) alive <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_merge.sv
`timescale 1ns/1ps
// Registered, non-latching combination of the health sources.
module rsv_merge
  import rsv_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  health_t hs,
  output logic    ready,
  output logic    force_off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b0;
      force_off <= 1'b1;
    end else begin
      ready     <= ready_permit(hs);
      force_off <= ~gate_permit(hs);
    end
  end
endmodule

// File: rtl/rsv_ready_supervisor.sv
`timescale 1ns/1ps
module rsv_ready_supervisor
  import rsv_pkg::*;
#(
  parameter int OUT_QUAL     = 8,
  parameter int LINK_QUAL    = 4,
  parameter int WDOG_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_supply_ok,
  input  logic out_supply_ok,
  input  logic link_strobe,
  output logic ready,
  output logic force_off
);
  logic                link_alive;
  logic [NUM_QUAL-1:0] raw_ok;
  logic [NUM_QUAL-1:0] qual_ok;
  health_t             hs;

  rsv_watchdog #(.TIMEOUT(WDOG_TIMEOUT)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .strobe (link_strobe),
    .alive  (link_alive)
  );

  always_comb begin
    raw_ok            = '0;
    raw_ok[QUAL_OUT]  = out_supply_ok;
    raw_ok[QUAL_LINK] = link_alive;
  end

  for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
    localparam int DLY = (g == QUAL_OUT) ? OUT_QUAL : LINK_QUAL;
    rsv_qualifier #(.DELAY(DLY)) u_q (
      .clk     (clk),
      .rst     (rst),
      .raw_ok  (raw_ok[g]),
      .qual_ok (qual_ok[g])
    );
  end

  always_comb begin
    hs.in_ok      = in_supply_ok;
    hs.out_ok     = out_supply_ok;
    hs.out_qual   = qual_ok[QUAL_OUT];
    hs.link_alive = link_alive;
    hs.link_qual  = qual_ok[QUAL_LINK];
  end

  rsv_merge u_merge (
    .clk       (clk),
    .rst       (rst),
    .hs        (hs),
    .ready     (ready),
    .force_off (force_off)
  );
endmodule

// File: rtl/rsv_ready_supervisor_chk.sv
`timescale 1ns/1ps
module rsv_ready_supervisor_chk #(
  parameter int OUT_QUAL     = 8,
  parameter int LINK_QUAL    = 4,
  parameter int WDOG_TIMEOUT = 16
) (
  input logic clk,
  input logic rst,
  input logic in_supply_ok,
  input logic out_supply_ok,
  input logic link_strobe,
  input logic ready,
  input logic force_off
);
  localparam int RW = $clog2(OUT_QUAL + 2);
  localparam int GW = $clog2(WDOG_TIMEOUT + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(OUT_QUAL + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(WDOG_TIMEOUT + 1);

  logic          past_rst;
  logic [RW-1:0] out_run;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst) begin
      out_run <= '0;
      gap_cnt <= '0;
    end else begin
      if (!out_supply_ok)        out_run <= '0;
      else if (out_run != RUN_MAX) out_run <= out_run + 1'b1;
      if (link_strobe)           gap_cnt <= '0;
      else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_reset_safe_r1: assert property (@(posedge clk) disable iff (rst)
    past_rst |-> (force_off && !ready));

  p_ready_supplies_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> ($past(in_supply_ok) && $past(out_supply_ok)));

  p_out_qual_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (out_run == RUN_MAX));

  p_wdog_timeout_r5: assert property (@(posedge clk) disable iff (rst)
    (gap_cnt == GAP_MAX) |-> (force_off && !ready));

  p_supply_loss_r6: assert property (@(posedge clk) disable iff (rst)
    !(in_supply_ok && out_supply_ok) |=> (force_off && !ready));

  p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ready |-> !force_off);
endmodule

bind rsv_ready_supervisor rsv_ready_supervisor_chk #(
  .OUT_QUAL     (OUT_QUAL),
  .LINK_QUAL    (LINK_QUAL),
  .WDOG_TIMEOUT (WDOG_TIMEOUT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_supply_ok  (in_supply_ok),
  .out_supply_ok (out_supply_ok),
  .link_strobe   (link_strobe),
  .ready         (ready),
  .force_off     (force_off)
);

// File: tb/rsv_ready_supervisor_test.sv
`timescale 1ns/1ps
module rsv_ready_supervisor_test;
  localparam int OQ = 8;
  localparam int LQ = 4;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_supply_ok = 1'b0;
  logic out_supply_ok = 1'b0;
  logic link_strobe = 1'b0;
  logic ready, force_off;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int sph = 0;
  int sper = 4;
  bit son = 0;

  always #2.5 clk = ~clk;

  rsv_ready_supervisor #(.OUT_QUAL(OQ), .LINK_QUAL(LQ), .WDOG_TIMEOUT(WD)) uut (
    .clk(clk), .rst(rst), .in_supply_ok(in_supply_ok), .out_supply_ok(out_supply_ok),
    .link_strobe(link_strobe), .ready(ready), .force_off(force_off)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic clk1();
    link_strobe = son && (sph % sper == 0);
    sph++;
    @(posedge clk); #1;
    link_strobe = 1'b0;
  endtask

  task automatic clkn(input int n);
    for (int i = 0; i < n; i++) clk1();
  endtask

  task automatic strobe_once();
    link_strobe = 1'b1;
    @(posedge clk); #1;
    link_strobe = 1'b0;
  endtask

  task automatic set_strobes(input bit on, input int per);
    son = on; sper = per; sph = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1; set_strobes(0, 4);
    clkn(3);
    check("R1", "ready in reset", ready, 1'b0);
    check("R1", "force_off in reset", force_off, 1'b1);
    in_supply_ok = 1'b1; out_supply_ok = 1'b1; set_strobes(1, 4);
    clkn(20);
    check("R1", "ready in reset with healthy inputs", ready, 1'b0);
    check("R1", "force_off in reset with healthy inputs", force_off, 1'b1);
    out_supply_ok = 1'b0; rst = 1'b0;
    clk1();
    check("R1", "ready first edge after reset", ready, 1'b0);
    check("R1", "force_off first edge after reset", force_off, 1'b1);
  endtask

  task automatic t_out_qual();
    clkn(12);
    check("R2", "ready with output supply bad", ready, 1'b0);
    check("R8", "force_off with output supply bad", force_off, 1'b1);
    out_supply_ok = 1'b1;
    clkn(OQ);
    check("R3", "ready before qualification ends", ready, 1'b0);
    check("R8", "force_off while output supply qualifies", force_off, 1'b1);
    clk1();
    check("R3", "ready at qualification end", ready, 1'b1);
    check("R8", "force_off released", force_off, 1'b0);
  endtask

  task automatic t_in_supply();
    in_supply_ok = 1'b0;
    clk1();
    check("R6", "ready after input supply loss", ready, 1'b0);
    check("R6", "force_off after input supply loss", force_off, 1'b1);
    in_supply_ok = 1'b1;
    clk1();
    check("R7", "ready back after input supply return", ready, 1'b1);
    check("R7", "force_off released after input supply return", force_off, 1'b0);
    in_supply_ok = 1'b0;
    clkn(10);
    check("R2", "ready held low while input supply bad", ready, 1'b0);
    in_supply_ok = 1'b1;
    clk1();
    check("R7", "ready recovers after long input loss", ready, 1'b1);
  endtask

  task automatic t_out_supply();
    out_supply_ok = 1'b0;
    clk1();
    check("R6", "ready after output supply loss", ready, 1'b0);
    check("R6", "force_off after output supply loss", force_off, 1'b1);
    out_supply_ok = 1'b1;
    clkn(OQ);
    check("R3", "ready during requalification", ready, 1'b0);
    clk1();
    check("R7", "ready back after output requalification", ready, 1'b1);
  endtask

  task automatic t_wdog();
    set_strobes(0, 4);
    strobe_once();
    clkn(WD);
    check("R5", "ready at timeout edge", ready, 1'b1);
    check("R5", "force_off at timeout edge", force_off, 1'b0);
    clk1();
    check("R5", "ready after watchdog expiry", ready, 1'b0);
    check("R5", "force_off after watchdog expiry", force_off, 1'b1);
    clkn(5);
    check("R5", "force_off held while link dead", force_off, 1'b1);
  endtask

  task automatic t_link_qual();
    strobe_once();
    clk1();
    check("R8", "force_off released before link qualifies", force_off, 1'b0);
    check("R4", "ready not yet after strobe", ready, 1'b0);
    clkn(LQ - 1);
    check("R4", "ready before link qualification ends", ready, 1'b0);
    clk1();
    check("R4", "ready after link qualification", ready, 1'b1);
  endtask

  task automatic t_keepalive();
    bit ok = 1;
    strobe_once();
    for (int k = 0; k < 3; k++) begin
      clkn(WD - 1);
      if (ready !== 1'b1 || force_off !== 1'b0) ok = 0;
      strobe_once();
      if (ready !== 1'b1 || force_off !== 1'b0) ok = 0;
    end
    check("R5", "ready kept by strobes at timeout spacing", ok, 1'b1);
    clkn(WD + 1);
    check("R5", "ready lost when strobes stop", ready, 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    set_strobes(1, 4);
    t_out_qual();
    t_in_supply();
    t_out_supply();
    t_wdog();
    t_link_qual();
    t_keepalive();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule